// File: doc/BRIEF.md
# Phase Count Detection and Interleaver

This block works out how many phases of a multiphase regulator are fitted and then hands out the cycle starts. Each populated phase gets one master clock tick in turn. While the startup sequencer holds the detection window, the block captures the digitized comparator levels of phase pins 2 to N. A pin that reads high has been strapped to the supply, so it is unused. A pin that reads low belongs to a fitted phase. Phase 1 is always fitted and is forced low for as long as the window lasts.

When the window closes, the block latches the phase count and enables the output drivers of the fitted phases. Unused pins stay high-impedance. From then on, each master clock tick produces one cycle-start pulse. The pulses rotate over the fitted phases, so each phase switches at the master rate divided by the phase count. Duty-cycle generation stays outside this block. Each phase is started independently, so the downstream pulse generators may overlap their outputs or run close to full duty.

The block is reset by `rst_n`. It is also cleared whenever the window is raised again, which allows detection to be repeated.

Top module: `phase_interleaver`

## Requirements
- R1: After reset, `det_done`, `strap_err`, `phase_cnt`, `oe` and `start` are all zero.
- R2: `phase_cnt` is 1 plus the number of consecutive low pins counted upward from `pin_hi[0]`, which is pin 2. `pin_hi[k]` is phase pin k+2. Only the levels present in the last cycle of the window are used. The value appears, with `det_done` = 1, on the clock edge that follows the window's last cycle.
- R3: `strap_err` is set on completion when any pin above the first high pin reads low. The count is then truncated at the first high pin.
- R4: `oe[i]` (bit i is phase i+1, and 1 means driven while 0 means high-impedance) is 1 exactly when `det_done` is 1, the window is low and i < `phase_cnt`.
- R5: `force_low` is high in exactly the cycles where `det_win` is high.
- R6: After detection, each cycle with `tick` high drives a one-hot `start` combinationally. The pulses go to phases 1, 2, …, `phase_cnt` and then wrap back to phase 1. Cycles without `tick` give `start` = 0.
- R7: Ticks are ignored while detection is not complete or while the window is high. They give no pulse and do not advance the rotation.
- R8: Raising `det_win` again makes `oe` zero at once. From the next edge it also clears `det_done`, `phase_cnt` and `strap_err`. The next completed detection restarts the rotation at phase 1.
- R9: With every sampled pin low, `phase_cnt` equals NPH, which is 6 by default, and no error is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| det_win | input | 1 | Detection window from the startup sequencer |
| pin_hi | input | NPH-1 | Comparator levels of phase pins 2..NPH (1 = strapped high) |
| tick | input | 1 | One-cycle master clock tick |
| start | output | NPH | One-hot cycle-start pulse per phase |
| oe | output | NPH | Per-phase output enable (0 = high-impedance) |
| force_low | output | 1 | Hold phase 1 low during detection |
| phase_cnt | output | $clog2(NPH+1) | Detected phase count, 0 before detection |
| det_done | output | 1 | Detection result valid |
| strap_err | output | 1 | Non-contiguous strap pattern seen |

## Verification
Detection is tried with the following strap patterns:
- All pins low, which must give the full count.
- Only the top pin high, which gives five phases.
- The upper three pins high, which gives three phases.
- Every pin high, which gives a single phase.
- A gapped pattern, which must raise the error flag and truncate at the first high pin.

Together these separate a count taken from the first high pin from one taken by popcount or from the top down.

A pattern that changes inside the window shows that only the final window cycle is latched. Ticks arriving before and during the window, together with long runs of ticks, show that the rotation wraps at the detected count and restarts at phase 1 after each detection.

// File: rtl/phase_interleaver.sv
module phase_interleaver #(
  parameter int NPH = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     det_win,
  input  logic [NPH-2:0]           pin_hi,
  input  logic                     tick,
  output logic [NPH-1:0]           start,
  output logic [NPH-1:0]           oe,
  output logic                     force_low,
  output logic [$clog2(NPH+1)-1:0] phase_cnt,
  output logic                     det_done,
  output logic                     strap_err
);
  localparam int CW = $clog2(NPH+1);
  localparam int PW = $clog2(NPH);

  logic [NPH-2:0] samp;
  logic           win_q;
  logic [PW-1:0]  ptr;
  logic [CW-1:0]  det_cnt;
  logic           det_err;
  logic           live;

  always_comb begin
    logic hit;
    hit     = 1'b0;
    det_cnt = CW'(1);
    det_err = 1'b0;
    for (int j = 0; j < NPH-1; j++) begin
      if (samp[j])  hit = 1'b1;
      else if (hit) det_err = 1'b1;
      else          det_cnt = CW'(j + 2);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp      <= '0;
      win_q     <= 1'b0;
      det_done  <= 1'b0;
      phase_cnt <= '0;
      strap_err <= 1'b0;
      ptr       <= '0;
    end else begin
      win_q <= det_win;
      if (det_win) begin
        samp      <= pin_hi;
        det_done  <= 1'b0;
        phase_cnt <= '0;
        strap_err <= 1'b0;
        ptr       <= '0;
      end else if (win_q) begin
        det_done  <= 1'b1;
        phase_cnt <= det_cnt;
        strap_err <= det_err;
        ptr       <= '0;
      end else if (live && tick) begin
        ptr <= (CW'(ptr) == phase_cnt - CW'(1)) ? '0 : ptr + PW'(1);
      end
    end
  end

  assign live      = det_done && !det_win;
  assign force_low = det_win;
  assign start     = (live && tick) ? (NPH'(1) << ptr) : '0;

  for (genvar i = 0; i < NPH; i++) begin : g_oe
    assign oe[i] = live && (CW'(i) < phase_cnt);
  end
endmodule

module phase_interleaver_chk #(
  parameter int NPH = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     det_win,
  input logic                     tick,
  input logic [NPH-1:0]           start,
  input logic [NPH-1:0]           oe,
  input logic                     force_low,
  input logic [$clog2(NPH+1)-1:0] phase_cnt,
  input logic                     det_done
);
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    det_done |-> (phase_cnt >= 1 && phase_cnt <= NPH));
  p_start_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start & ~oe) == '0);
  p_force_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    force_low |-> !oe[0]);
  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start));
  p_tick_needed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> start == '0);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !det_done |-> start == '0);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    det_win |-> oe == '0);
  p_clear_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    det_win |=> !det_done);
endmodule

bind phase_interleaver phase_interleaver_chk #(.NPH(NPH)) u_chk (.*);

// File: tb/phase_interleaver_test.sv
module phase_interleaver_test;
  localparam int NPH = 6;
  localparam int CW  = $clog2(NPH+1);

  logic clk = 1'b0;
  logic rst_n, det_win, tick;
  logic [NPH-2:0] pin_hi;
  logic [NPH-1:0] start, oe;
  logic force_low, det_done, strap_err;
  logic [CW-1:0] phase_cnt;

  phase_interleaver #(.NPH(NPH)) uut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  string req = "R1";

  int m_done = 0, m_cnt = 0, m_err = 0, m_ptr = 0, m_winq = 0;
  logic [NPH-2:0] m_samp = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_done = 0; m_cnt = 0; m_err = 0; m_ptr = 0; m_winq = 0; m_samp = '0;
    end else begin
      if (det_win) begin
        m_samp = pin_hi; m_done = 0; m_cnt = 0; m_err = 0; m_ptr = 0;
      end else if (m_winq != 0) begin
        int c;
        c = 1;
        while (c < NPH && !m_samp[c-1]) c++;
        m_err = 0;
        for (int j = c; j < NPH-1; j++) if (!m_samp[j]) m_err = 1;
        m_cnt = c; m_done = 1; m_ptr = 0;
      end else if (m_done != 0 && tick) begin
        m_ptr = (m_ptr + 1) % m_cnt;
      end
      m_winq = det_win ? 1 : 0;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    int live, e_oe, e_st;
    live = (m_done != 0 && !det_win) ? 1 : 0;
    e_oe = 0;
    for (int i = 0; i < NPH; i++) if (live != 0 && i < m_cnt) e_oe |= (1 << i);
    e_st = (live != 0 && tick) ? (1 << m_ptr) : 0;
    chk("oe", int'(oe), e_oe);
    chk("start", int'(start), e_st);
    chk("force_low", int'(force_low), int'(det_win));
    chk("phase_cnt", int'(phase_cnt), m_cnt);
    chk("det_done", int'(det_done), m_done);
    chk("strap_err", int'(strap_err), m_err);
  endtask

  task automatic cyc(input logic w, input logic [NPH-2:0] p, input logic t);
    @(negedge clk);
    det_win = w; pin_hi = p; tick = t;
    #1 compare();
  endtask

  task automatic detect(input logic [NPH-2:0] p);
    for (int k = 0; k < 6; k++) cyc(1'b1, p, 1'b0);
    cyc(1'b0, '0, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, '0, 1'b1);
  endtask

  initial begin
    #500000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; det_win = 1'b0; pin_hi = '0; tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req = "R1"; cyc(1'b0, '0, 1'b0);
    req = "R7"; ticks(4);
    req = "R9"; detect(5'b00000); cyc(1'b0, '0, 1'b0);
    req = "R6"; ticks(14);
    cyc(1'b0, '0, 1'b0); ticks(3);
    req = "R5"; detect(5'b10000);
    req = "R2"; ticks(11);
    req = "R8"; cyc(1'b1, 5'b11100, 1'b1); cyc(1'b1, 5'b11100, 1'b1);
    for (int k = 0; k < 4; k++) cyc(1'b1, 5'b11100, 1'b1);
    cyc(1'b0, '0, 1'b1); ticks(8);
    req = "R2"; detect(5'b11111); ticks(5);
    req = "R3"; detect(5'b10100); ticks(7);
    req = "R3"; detect(5'b01010); ticks(3);
    req = "R2";
    cyc(1'b1, 5'b11111, 1'b0); cyc(1'b1, 5'b11111, 1'b0); cyc(1'b1, 5'b11000, 1'b0);
    cyc(1'b0, 5'b11111, 1'b0); ticks(9);
    req = "R4"; detect(5'b11110); ticks(4);
    req = "R1"; @(negedge clk); rst_n = 1'b0; cyc(1'b0, '0, 1'b1); rst_n = 1'b1;
    cyc(1'b0, '0, 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule